// File: doc/BRIEF.md
# DMA Channel Word Counter with Autoinitialize

This block holds the address and word-count state of one transfer channel. Each of the two quantities lives in a pair of 16-bit registers. The current copy moves as transfers happen. The base copy keeps the value the host last programmed.

The host reaches the registers one byte at a time through an 8-bit port. A byte pointer decides which half of the word a read or write touches. Every write lands in the current copy and the base copy in the same edge. Only the current copy can be read back.

Each transfer pulse does two things: it lowers the count by one and moves the address one step in the programmed direction. A count of N therefore gives N+1 transfers. The block flags terminal count when the count wraps from 0000h to FFFFh. Terminal count and an external end-of-process pulse together form the end-of-process event. When autoinitialize is on, that event copies the base values back into the current registers.

Top module: `xfer_count_chan`

## Requirements
- R1: While `rst_n` is low, `cur_addr`, `cur_count`, both base copies, `tc` and `eop_out` are all zero, and the byte pointer selects the low byte.
- R2: The byte pointer starts on the low byte (bits 7:0) and moves to the other byte after every access, read or write. Asserting `ptr_clr` puts it back on the low byte. If `ptr_clr` arrives in the same cycle as an access, that access still uses the old pointer value, and the pointer then ends on the low byte.
- R3: A write with `reg_sel`=0 targets the address register and `reg_sel`=1 targets the count register. The byte the pointer selects is written into the current copy and the base copy together. The other byte keeps its value.
- R4: `rd_data` shows the byte of the current copy of the selected register that the pointer selects. The base copy is never visible on `rd_data`.
- R5: Each cycle with `xfer` high lowers `cur_count` by one, modulo 2^16.
- R6: Each cycle with `xfer` high moves `cur_addr` by one, modulo 2^16. It goes up when `addr_down`=0 and down when `addr_down`=1.
- R7: `tc` is a one-cycle pulse in the cycle after a transfer that finds `cur_count` at 0000h. A programmed count of N therefore gives `tc` on transfer N+1.
- R8: `eop_out` is a one-cycle pulse in the cycle after a cycle where either the terminal-count condition or `eop_in` is present.
- R9: When the end-of-process event occurs with `auto_init`=1, both current registers take their base values at that edge. With `auto_init`=0, `cur_count` stays at FFFFh after terminal count. A lone `eop_in` with `auto_init`=0 leaves both registers unchanged.
- R10: A host write to a register in the same cycle as a transfer or reload wins for that register. The other register still follows the transfer or reload.
- R11: A terminal transfer and `eop_in` in the same cycle with `auto_init`=1 produce one reload, one `tc` pulse and one `eop_out` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptr_clr | input | 1 | Returns the byte pointer to the low byte |
| wr_en | input | 1 | Host byte write strobe |
| rd_en | input | 1 | Host byte read strobe (advances the pointer) |
| reg_sel | input | 1 | 0 = address register, 1 = count register |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Selected byte of the selected current register |
| addr_down | input | 1 | Address steps down when 1, up when 0 |
| auto_init | input | 1 | Enables reload from the base copies on end of process |
| xfer | input | 1 | One transfer per cycle while high |
| eop_in | input | 1 | External end-of-process pulse |
| tc | output | 1 | Terminal-count pulse |
| eop_out | output | 1 | End-of-process pulse (terminal count or external) |
| cur_addr | output | 16 | Current address |
| cur_count | output | 16 | Current word count |

## Verification
Two pairs of functions can meet in one clock edge, and the bench drives both.

The first pair is the terminal transfer and the external end-of-process pulse. The bench sets the count to zero with autoinitialize on, then raises `xfer` and `eop_in` together. It expects a single reload to the base values, plus `tc` and `eop_out` each high for exactly one cycle.

The second pair is a host byte write landing on a transfer. The bench expects the written register to take the merged byte with no decrement. The address register must still step.

A behavioural model in the bench follows every cycle and compares all registered outputs on each falling edge.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int NREGS  = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PTR_W-1:0]  ptr_t;

  // register selector on the host port
  typedef enum logic {
    SEL_ADDR  = 1'b0,
    SEL_COUNT = 1'b1
  } reg_sel_e;

  // one step of a current register, downward or upward
  function automatic word_t step_word(word_t w, logic down);
    return down ? word_t'(w - word_t'(1)) : word_t'(w + word_t'(1));
  endfunction

  // count sits at the value whose decrement wraps
  function automatic logic at_wrap(word_t w);
    return (w == '0);
  endfunction

  // replace one byte lane of a word
  function automatic word_t merge_byte(word_t old, byte_t d, ptr_t idx);
    word_t r;
    r = old;
    r[idx*BYTE_W +: BYTE_W] = d;
    return r;
  endfunction

  // extract one byte lane of a word
  function automatic byte_t pick_byte(word_t w, ptr_t idx);
    return w[idx*BYTE_W +: BYTE_W];
  endfunction

  // pointer advance with wrap at the last lane
  function automatic ptr_t next_ptr(ptr_t p);
    return (p == ptr_t'(NBYTES-1)) ? '0 : ptr_t'(p + ptr_t'(1));
  endfunction

endpackage

// File: rtl/xfer_byte_ptr.sv
module xfer_byte_ptr
  import xfer_count_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic access,
  output ptr_t ptr
);

  ptr_t ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (clr) begin
      ptr_q <= '0;
    end else if (access) begin
      ptr_q <= next_ptr(ptr_q);
    end
  end

  assign ptr = ptr_q;

  AST_PTR_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr == '0)); // R2

  AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !clr) |=> (ptr != $past(ptr))); // R2

  AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && !clr) |=> $stable(ptr)); // R2

endmodule

// File: rtl/xfer_word_pair.sv
module xfer_word_pair
  import xfer_count_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ptr_t  wr_idx,
  input  byte_t wr_data,
  input  logic  step,
  input  logic  down,
  input  logic  reload,
  output word_t cur
);

  word_t cur_q;
  word_t base_q;
  word_t stepped;
  word_t cur_nxt;
  word_t base_nxt;

  assign stepped  = step_word(cur_q, down);
  assign base_nxt = merge_byte(base_q, wr_data, wr_idx);

  // priority: host write over reload over step
  always_comb begin
    cur_nxt = cur_q;
    if (step)   cur_nxt = stepped;
    if (reload) cur_nxt = base_q;
    if (wr_en)  cur_nxt = merge_byte(cur_q, wr_data, wr_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      base_q <= '0;
    end else begin
      cur_q <= cur_nxt;
      if (wr_en) base_q <= base_nxt;
    end
  end

  assign cur = cur_q;

  AST_BASE_HOST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_q)); // R3

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pick_byte(cur_q, $past(wr_idx)) == $past(wr_data))); // R10

  AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !wr_en) |=> (cur_q == $past(base_q))); // R9

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload && !wr_en) |=>
      (cur_q == ($past(down) ? word_t'($past(cur_q) - 1'b1)
                             : word_t'($past(cur_q) + 1'b1)))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !reload && !wr_en) |=> $stable(cur_q)); // R6

endmodule

// File: rtl/xfer_count_chan.sv
module xfer_count_chan
  import xfer_count_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_clr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              addr_down,
  input  logic              auto_init,
  input  logic              xfer,
  input  logic              eop_in,
  output logic              tc,
  output logic              eop_out,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] cur_count
);

  // named internal events
  ptr_t  ptr;
  logic  host_access;
  logic  cnt_zero;
  logic  wrap_evt;
  logic  end_evt;
  logic  reload_evt;
  word_t cur_w [NREGS];
  logic  tc_q;
  logic  eop_q;

  assign host_access = wr_en | rd_en;

  xfer_byte_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ptr_clr),
    .access (host_access),
    .ptr    (ptr)
  );

  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    logic k_wr;
    logic k_down;
    assign k_wr   = wr_en && (reg_sel == k[0]);
    assign k_down = (k == int'(SEL_COUNT)) ? 1'b1 : addr_down;

    xfer_word_pair u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (k_wr),
      .wr_idx  (ptr),
      .wr_data (wr_data),
      .step    (xfer),
      .down    (k_down),
      .reload  (reload_evt),
      .cur     (cur_w[k])
    );
  end

  assign cur_addr   = cur_w[SEL_ADDR];
  assign cur_count  = cur_w[SEL_COUNT];
  assign cnt_zero   = at_wrap(cur_count);
  assign wrap_evt   = xfer & cnt_zero;
  assign end_evt    = wrap_evt | eop_in;
  assign reload_evt = end_evt & auto_init;
  assign rd_data    = pick_byte(cur_w[reg_sel], ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q  <= 1'b0;
      eop_q <= 1'b0;
    end else begin
      tc_q  <= wrap_evt;
      eop_q <= end_evt;
    end
  end

  assign tc      = tc_q;
  assign eop_out = eop_q;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (cur_count == '0 && cur_addr == '0 && !tc && !eop_out)); // R1

  AST_TC_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && cur_count == '0) |=> tc); // R7

  AST_TC_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> ($past(xfer) && $past(cur_count) == '0)); // R7

  AST_EOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_in || (xfer && cur_count == '0)) |=> eop_out); // R8

  AST_HOLD_FFFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !auto_init && !(wr_en && reg_sel)) |=> (cur_count == '1)); // R9

  AST_LONE_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_in && !auto_init && !xfer && !wr_en) |=>
      ($stable(cur_count) && $stable(cur_addr))); // R9

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_out && !$past(end_evt, 2)) |=> !eop_out || $past(end_evt)); // R11

endmodule

// File: tb/xfer_count_chan_tb_top.sv
module xfer_count_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_clr = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic        addr_down = 1'b0;
  logic        auto_init = 1'b0;
  logic        xfer = 1'b0;
  logic        eop_in = 1'b0;
  logic        tc;
  logic        eop_out;
  logic [15:0] cur_addr;
  logic [15:0] cur_count;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string cur_req = "R1";

  always #2 clk = ~clk; // 250 MHz

  xfer_count_chan dut_i (
    .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .addr_down(addr_down), .auto_init(auto_init), .xfer(xfer), .eop_in(eop_in),
    .tc(tc), .eop_out(eop_out), .cur_addr(cur_addr), .cur_count(cur_count)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_addr, m_cnt, m_baddr, m_bcnt, m_ptr, m_tc, m_eop;
  int na, nc, wrap, ev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_cnt = 0; m_baddr = 0; m_bcnt = 0;
      m_ptr = 0; m_tc = 0; m_eop = 0;
    end else begin
      wrap = (xfer && m_cnt == 0) ? 1 : 0;
      ev   = (wrap == 1 || eop_in) ? 1 : 0;
      na = m_addr; nc = m_cnt;
      if (xfer) begin
        na = addr_down ? (m_addr + 65535) % 65536 : (m_addr + 1) % 65536;
        nc = (m_cnt + 65535) % 65536;
      end
      if (ev == 1 && auto_init) begin na = m_baddr; nc = m_bcnt; end
      if (wr_en) begin
        if (reg_sel) begin
          nc      = m_ptr == 1 ? (wr_data * 256 + m_cnt % 256)  : ((m_cnt / 256) * 256 + wr_data);
          m_bcnt  = m_ptr == 1 ? (wr_data * 256 + m_bcnt % 256) : ((m_bcnt / 256) * 256 + wr_data);
        end else begin
          na      = m_ptr == 1 ? (wr_data * 256 + m_addr % 256)  : ((m_addr / 256) * 256 + wr_data);
          m_baddr = m_ptr == 1 ? (wr_data * 256 + m_baddr % 256) : ((m_baddr / 256) * 256 + wr_data);
        end
      end
      if (ptr_clr) m_ptr = 0;
      else if (wr_en || rd_en) m_ptr = 1 - m_ptr;
      m_addr = na; m_cnt = nc; m_tc = wrap; m_eop = ev;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "model cur_count", int'(cur_count), m_cnt);
      chk(cur_req, "model cur_addr",  int'(cur_addr),  m_addr);
      chk(cur_req, "model tc",        int'(tc),        m_tc);
      chk(cur_req, "model eop_out",   int'(eop_out),   m_eop);
    end
  end

  // each task starts and ends at a falling edge
  task automatic host_wr(logic sel, logic [7:0] d);
    wr_en = 1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic host_rd(logic sel, int exp, string req);
    rd_en = 1; reg_sel = sel;
    #1 chk(req, "rd_data", int'(rd_data), exp);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic pulse(logic x, logic e);
    xfer = x; eop_in = e;
    @(negedge clk);
    xfer = 0; eop_in = 0;
  endtask

  task automatic clr_ptr();
    ptr_clr = 1;
    @(negedge clk);
    ptr_clr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "cur_count", int'(cur_count), 0);
    chk("R1", "cur_addr",  int'(cur_addr),  0);
    chk("R1", "tc",        int'(tc),        0);
    chk("R1", "eop_out",   int'(eop_out),   0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 byte-wise programming
    cur_req = "R3";
    host_wr(0, 8'h34); host_wr(0, 8'h12);
    chk("R3", "cur_addr", int'(cur_addr), 16'h1234);
    host_wr(1, 8'h03); host_wr(1, 8'h00);
    chk("R3", "cur_count", int'(cur_count), 16'h0003);

    // R4 read back low then high byte
    cur_req = "R4";
    host_rd(1, 8'h03, "R4");
    host_rd(1, 8'h00, "R4");
    host_rd(0, 8'h34, "R4");
    host_rd(0, 8'h12, "R4");

    // R5 R6 R7 count plus one transfers, upward address
    cur_req = "R7";
    addr_down = 0;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      pulse(1, 0);
      n++;
      if (tc) break;
    end
    chk("R7", "transfers until tc", n, 4);
    chk("R6", "cur_addr up", int'(cur_addr), 16'h1238);
    chk("R5", "cur_count wrapped", int'(cur_count), 16'hFFFF);
    repeat (3) @(negedge clk);
    chk("R9", "count holds FFFF", int'(cur_count), 16'hFFFF);
    chk("R7", "tc single pulse", int'(tc), 0);

    // R4 base never visible: current FFFF, base 0003
    cur_req = "R4";
    host_rd(1, 8'hFF, "R4");
    host_rd(1, 8'hFF, "R4");

    // R6 downward with wrap
    cur_req = "R6";
    addr_down = 1;
    host_wr(0, 8'h01); host_wr(0, 8'h00);
    host_wr(1, 8'h05); host_wr(1, 8'h00);
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    chk("R6", "cur_addr down wrap", int'(cur_addr), 16'hFFFE);
    chk("R5", "cur_count after 3", int'(cur_count), 16'h0002);

    // R2 pointer clear, and clear together with a write
    cur_req = "R2";
    host_wr(0, 8'hAA);
    chk("R2", "low byte first", int'(cur_addr), 16'hFFAA);
    clr_ptr();
    host_wr(0, 8'hBB);
    chk("R2", "low byte after clear", int'(cur_addr), 16'hFFBB);
    ptr_clr = 1;
    host_wr(0, 8'hCC);
    ptr_clr = 0;
    chk("R2", "write with clear uses high", int'(cur_addr), 16'hCCBB);
    host_wr(0, 8'hDD);
    chk("R2", "pointer back on low", int'(cur_addr), 16'hCCDD);

    // R9 autoinitialize on terminal count and on external pulse
    cur_req = "R9";
    clr_ptr();
    addr_down = 0; auto_init = 1;
    host_wr(0, 8'h00); host_wr(0, 8'h01);
    host_wr(1, 8'h02); host_wr(1, 8'h00);
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    chk("R9", "reload count", int'(cur_count), 16'h0002);
    chk("R9", "reload addr", int'(cur_addr), 16'h0100);
    chk("R7", "tc on wrap with reload", int'(tc), 1);
    pulse(1, 0);
    pulse(0, 1);
    chk("R9", "eop reload count", int'(cur_count), 16'h0002);
    chk("R9", "eop reload addr", int'(cur_addr), 16'h0100);
    chk("R8", "eop_out on eop_in", int'(eop_out), 1);
    chk("R8", "no tc on eop_in", int'(tc), 0);

    // R9 lone eop without autoinitialize changes nothing
    auto_init = 0;
    pulse(1, 0);
    pulse(0, 1);
    chk("R9", "count unchanged", int'(cur_count), 16'h0001);
    chk("R9", "addr unchanged", int'(cur_addr), 16'h0101);
    chk("R8", "eop_out pulse", int'(eop_out), 1);

    // R11 terminal transfer and eop_in together
    cur_req = "R11";
    auto_init = 1;
    pulse(1, 0);
    chk("R11", "count at zero", int'(cur_count), 0);
    pulse(1, 1);
    chk("R11", "single reload count", int'(cur_count), 16'h0002);
    chk("R11", "single reload addr", int'(cur_addr), 16'h0100);
    chk("R11", "tc", int'(tc), 1);
    chk("R11", "eop_out", int'(eop_out), 1);
    @(negedge clk);
    chk("R11", "eop_out one cycle", int'(eop_out), 0);
    chk("R11", "tc one cycle", int'(tc), 0);

    // R10 host write meets a transfer
    cur_req = "R10";
    auto_init = 0;
    clr_ptr();
    xfer = 1;
    host_wr(1, 8'h09);
    xfer = 0;
    chk("R10", "write wins on count", int'(cur_count), 16'h0009);
    chk("R10", "address still steps", int'(cur_addr), 16'h0101);
    host_wr(1, 8'h00);
    chk("R10", "high byte", int'(cur_count), 16'h0009);

    @(negedge clk);
    finish_run();
  end

endmodule